// File: doc/BRIEF.md
# PCIe Configuration-Load Sequencer

This block is a hardware master that loads a configuration bitstream into a target device. It reaches the target through a simple 32-bit register bus that stands in for configuration-space reads and writes. A run starts with one `start` pulse. The sequencer first confirms that the target allows loading. It then brings the target into load mode step by step, streams the bitstream words into the target's data register, tears the load session down, and waits until the target reports that it is running in user mode.

Every register change is a read-modify-write, so bits the sequencer does not own keep their values. At three points the sequencer sets the clocks-per-word field to one and issues a fixed burst of throw-away data writes. These bursts move the target between its own clock and the link clock. Each status poll stops after a programmable number of reads. A run ends with a one-cycle `done` pulse and a result code that stays valid until the next start. A run that fails a check or runs out of poll reads ends the same way, with `busy` low.

Top module: `cfg_load_seq`

## Requirements
- R1: Only one bus transaction is outstanding at a time. `reg_req` stays high, with `reg_we`, `reg_addr` and `reg_wdata` unchanged, until the cycle in which `reg_ack` is high. Read data is taken in that cycle.
- R2: On start, the status register (address 0x1C) is read. If its load-enable bit 20 is clear, the run ends with code 1 and no register is written.
- R3: Bring-up first writes the mode register (0x20) with the clock-select bit 1 set. Only after that, in a separate write, does it set the load-mode bit 0.
- R4: A clock switch writes the value 1 into mode-register bits 15:8 and keeps all other bits. It then issues DUMMY_WRITES (default 244) writes to the data register (0x28). A switch follows the load-mode write, follows the detection of config-ready, and is part of teardown, so a clean run issues 732 dummy writes.
- R5: After bit 0 (config request) of the program register (0x2C) is set, status bit 18 (config ready) is polled until it reads 1. A timeout ends the run with code 2.
- R6: After that clock switch, program-register bit 1 (start transfer) is set. Then mode bits 15:8 are set to a clocks-per-word count chosen from `img_type`: 2'b00 (plain) gives 1, 2'b01 (encrypted) gives 4, and 2'b1x (compressed) gives 8.
- R7: Stream words go to the data register in the order they arrive. On the word marked last, a nonzero `word_bytes` value of 1, 2 or 3 keeps only that many low bytes and sets the upper bytes to zero. A value of 0 keeps the whole word.
- R8: Teardown reads the program register. It writes it back with bit 1 cleared, then writes it again with bits 1 and 0 cleared. It then performs a clock switch and polls status bit 18 until it reads 0. A timeout ends the run with code 3.
- R9: If status bit 18 is already set when the run starts, a full teardown runs first, and bring-up follows it (976 dummy writes in total).
- R10: After the final teardown, bit 5 of the error register (0x34) is read; if it is set, the run ends with code 4. Otherwise mode bits 1:0 are cleared, and status is polled until bits 21 and 24 are both 1. That ends the run with code 0, and a timeout ends it with code 5.
- R11: With `chk_en` high, status bit 19 is read after every CHK_WORDS (default 1024) data words and after the last word. If the bit is set, the run ends with code 6 and streaming stops.
- R12: Each poll point reads status at most `poll_limit` times (treated as 1 when the limit is 0) before it times out. Every run ends with `done` high for exactly one cycle and `busy` low in that same cycle. `err_code` holds its value until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a load run (accepted while idle) |
| img_type | input | 2 | Image kind: 00 plain, 01 encrypted, 1x compressed |
| chk_en | input | 1 | Enable periodic and final config-error checks |
| poll_limit | input | TW | Maximum status reads per poll point |
| word_valid | input | 1 | Bitstream word available |
| word_data | input | 32 | Bitstream word |
| word_last | input | 1 | This word ends the stream |
| word_bytes | input | 2 | Valid bytes of the last word (0 means 4) |
| word_ready | output | 1 | Sequencer takes the word this cycle |
| reg_req | output | 1 | Register transaction pending |
| reg_we | output | 1 | 1 for write, 0 for read |
| reg_addr | output | 8 | Register address |
| reg_wdata | output | 32 | Write data |
| reg_ack | input | 1 | Target completes the transaction |
| reg_rdata | input | 32 | Read data, valid with `reg_ack` |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| err_code | output | 4 | Result of the last run (0 = success) |

## Verification
Each bus step moves forward at the clock edge where `reg_ack` is high, and the next request appears in the following cycle. A run's result therefore comes two edges after the acknowledge of its deciding read: one edge to enter the finish state, and one more to raise `done` and drop `busy`. The bench does not predict a fixed cycle number for a whole run. It waits on falling edges for `done`. It then checks `busy` and `err_code` in that same cycle and checks `done` low one cycle later. All register effects (dummy-write counts, write order, streamed data, final bit values) are collected by the bench's target model as the writes are acknowledged, and they are compared only after `done`.

// File: rtl/cfg_load_pkg.sv
// Shared constants and types for the configuration-load sequencer.
// Assumes a target whose register layout matches the addresses below.
package cfg_load_pkg;
    localparam logic [7:0] A_STAT = 8'h1C;
    localparam logic [7:0] A_MODE = 8'h20;
    localparam logic [7:0] A_DATA = 8'h28;
    localparam logic [7:0] A_PROG = 8'h2C;
    localparam logic [7:0] A_ELAT = 8'h34;

    localparam int B_RDY   = 18;
    localparam int B_CERR  = 19;
    localparam int B_LDEN  = 20;
    localparam int B_UMODE = 21;
    localparam int B_FCLK  = 24;
    localparam int B_LATCH = 5;

    typedef enum logic [3:0] {
        E_OK      = 4'd0,
        E_NOLOAD  = 4'd1,
        E_RDY1_TO = 4'd2,
        E_RDY0_TO = 4'd3,
        E_LATCHED = 4'd4,
        E_USER_TO = 4'd5,
        E_CFGERR  = 4'd6
    } err_t;

    typedef enum logic [4:0] {
        S_IDLE, S_CHK, S_CKS_RD, S_CKS_WR, S_MOD_RD, S_MOD_WR,
        S_SW_RD, S_SW_WR, S_SW_DUM, S_REQ_RD, S_REQ_WR, S_POLL1,
        S_XF_RD, S_XF_WR, S_NC_RD, S_NC_WR, S_STRM, S_DWR, S_ECHK,
        S_TD_RD, S_TD_WR1, S_TD_WR2, S_POLL0, S_LAT, S_UM_RD,
        S_UM_WR, S_POLLU, S_FIN
    } st_t;
endpackage

// File: rtl/cfg_load_cnt.sv
// Up-counter with synchronous clear (clear wins over increment).
// Assumes the caller keeps the count below 2**W.
module cfg_load_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    // Count events; clear or reset returns to zero.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt <= '0;
        else if (inc)      cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/cfg_load_tail.sv
// Zeroes the unused upper bytes of a final partial word.
// Assumes bytes==0 means the whole word is valid.
module cfg_load_tail #(
    parameter int DW = 32
) (
    input  logic [DW-1:0] din,
    input  logic          last,
    input  logic [1:0]    nbytes,
    output logic [DW-1:0] dout
);
    localparam int NB = DW / 8;

    for (genvar b = 0; b < NB; b++) begin : g_byte
        logic keep;
        // Keep a byte unless it lies past the valid count of a last word.
        assign keep = !last || (nbytes == 2'd0) || (b < int'(nbytes));
        assign dout[b*8 +: 8] = keep ? din[b*8 +: 8] : 8'h00;
    end
endmodule

// File: rtl/cfg_load_seq.sv
// Configuration-load sequencer: bring-up, clock switches, bitstream
// streaming, teardown and return to user mode over a register bus.
// Assumes the target acknowledges each request within finite time.
module cfg_load_seq
    import cfg_load_pkg::*;
#(
    parameter int TW           = 16,
    parameter int DUMMY_WRITES = 244,
    parameter int CHK_WORDS    = 1024
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    img_type,
    input  logic          chk_en,
    input  logic [TW-1:0] poll_limit,
    input  logic          word_valid,
    input  logic [31:0]   word_data,
    input  logic          word_last,
    input  logic [1:0]    word_bytes,
    output logic          word_ready,
    output logic          reg_req,
    output logic          reg_we,
    output logic [7:0]    reg_addr,
    output logic [31:0]   reg_wdata,
    input  logic          reg_ack,
    input  logic [31:0]   reg_rdata,
    output logic          busy,
    output logic          done,
    output logic [3:0]    err_code
);
    localparam int DCW = $clog2(DUMMY_WRITES);
    localparam int WCW = $clog2(CHK_WORDS);

    st_t         state, sw_ret, td_ret;
    logic [31:0] val_q, wbuf;
    logic [7:0]  nclk_q;
    logic        last_q, done_q;
    err_t        err_q;

    logic [TW-1:0]  poll_cnt;
    logic [DCW-1:0] dum_cnt;
    logic [WCW-1:0] wcnt;
    logic [31:0]    masked;

    wire poll_st   = (state == S_POLL1) || (state == S_POLL0) || (state == S_POLLU);
    wire to_hit    = ({1'b0, poll_cnt} + 1'b1) >= {1'b0, poll_limit};
    wire dum_end   = (dum_cnt == DCW'(DUMMY_WRITES - 1));
    wire dwr_ack   = (state == S_DWR) && reg_ack;
    wire chunk_end = (wcnt == WCW'(CHK_WORDS - 1));

    cfg_load_cnt #(.W(TW)) u_poll (
        .clk(clk), .rst_n(rst_n), .clr(!poll_st),
        .inc(poll_st && reg_ack), .cnt(poll_cnt));

    cfg_load_cnt #(.W(DCW)) u_dum (
        .clk(clk), .rst_n(rst_n), .clr(state != S_SW_DUM),
        .inc((state == S_SW_DUM) && reg_ack), .cnt(dum_cnt));

    cfg_load_cnt #(.W(WCW)) u_wcnt (
        .clk(clk), .rst_n(rst_n), .clr((state == S_IDLE) || (dwr_ack && chunk_end)),
        .inc(dwr_ack), .cnt(wcnt));

    cfg_load_tail #(.DW(32)) u_tail (
        .din(word_data), .last(word_last), .nbytes(word_bytes), .dout(masked));

    // Drive the bus request for the current step.
    always_comb begin
        reg_req   = 1'b1;
        reg_we    = 1'b0;
        reg_addr  = A_STAT;
        reg_wdata = '0;
        case (state)
            S_CHK, S_POLL1, S_POLL0, S_POLLU, S_ECHK: reg_addr = A_STAT;
            S_CKS_RD, S_MOD_RD, S_SW_RD, S_NC_RD, S_UM_RD: reg_addr = A_MODE;
            S_REQ_RD, S_XF_RD, S_TD_RD: reg_addr = A_PROG;
            S_LAT: reg_addr = A_ELAT;
            S_CKS_WR: begin reg_we = 1'b1; reg_addr = A_MODE; reg_wdata = val_q | 32'h2; end
            S_MOD_WR: begin reg_we = 1'b1; reg_addr = A_MODE; reg_wdata = val_q | 32'h1; end
            S_SW_WR:  begin reg_we = 1'b1; reg_addr = A_MODE;
                            reg_wdata = {val_q[31:16], 8'd1, val_q[7:0]}; end
            S_SW_DUM: begin reg_we = 1'b1; reg_addr = A_DATA; reg_wdata = '0; end
            S_REQ_WR: begin reg_we = 1'b1; reg_addr = A_PROG; reg_wdata = val_q | 32'h1; end
            S_XF_WR:  begin reg_we = 1'b1; reg_addr = A_PROG; reg_wdata = val_q | 32'h2; end
            S_NC_WR:  begin reg_we = 1'b1; reg_addr = A_MODE;
                            reg_wdata = {val_q[31:16], nclk_q, val_q[7:0]}; end
            S_DWR:    begin reg_we = 1'b1; reg_addr = A_DATA; reg_wdata = wbuf; end
            S_TD_WR1: begin reg_we = 1'b1; reg_addr = A_PROG; reg_wdata = val_q & ~32'h2; end
            S_TD_WR2: begin reg_we = 1'b1; reg_addr = A_PROG; reg_wdata = val_q & ~32'h3; end
            S_UM_WR:  begin reg_we = 1'b1; reg_addr = A_MODE; reg_wdata = val_q & ~32'h3; end
            default:  reg_req = 1'b0;
        endcase
    end

    assign word_ready = (state == S_STRM);
    assign busy       = (state != S_IDLE);
    assign done       = done_q;
    assign err_code   = err_q;

    // Sequence the load steps; each bus step advances on its acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            sw_ret <= S_IDLE;
            td_ret <= S_IDLE;
            val_q  <= '0;
            wbuf   <= '0;
            nclk_q <= 8'd1;
            last_q <= 1'b0;
            done_q <= 1'b0;
            err_q  <= E_OK;
        end else begin
            done_q <= 1'b0;
            if (reg_req && !reg_we && reg_ack) val_q <= reg_rdata;
            case (state)
                S_IDLE: if (start) begin
                    err_q  <= E_OK;
                    nclk_q <= img_type[1] ? 8'd8 : (img_type[0] ? 8'd4 : 8'd1);
                    state  <= S_CHK;
                end
                S_CHK: if (reg_ack) begin
                    if (!reg_rdata[B_LDEN]) begin err_q <= E_NOLOAD; state <= S_FIN; end
                    else if (reg_rdata[B_RDY]) begin td_ret <= S_CKS_RD; state <= S_TD_RD; end
                    else state <= S_CKS_RD;
                end
                S_CKS_RD: if (reg_ack) state <= S_CKS_WR;
                S_CKS_WR: if (reg_ack) state <= S_MOD_RD;
                S_MOD_RD: if (reg_ack) state <= S_MOD_WR;
                S_MOD_WR: if (reg_ack) begin sw_ret <= S_REQ_RD; state <= S_SW_RD; end
                S_SW_RD:  if (reg_ack) state <= S_SW_WR;
                S_SW_WR:  if (reg_ack) state <= S_SW_DUM;
                S_SW_DUM: if (reg_ack && dum_end) state <= sw_ret;
                S_REQ_RD: if (reg_ack) state <= S_REQ_WR;
                S_REQ_WR: if (reg_ack) state <= S_POLL1;
                S_POLL1: if (reg_ack) begin
                    if (reg_rdata[B_RDY]) begin sw_ret <= S_XF_RD; state <= S_SW_RD; end
                    else if (to_hit) begin err_q <= E_RDY1_TO; state <= S_FIN; end
                end
                S_XF_RD: if (reg_ack) state <= S_XF_WR;
                S_XF_WR: if (reg_ack) state <= S_NC_RD;
                S_NC_RD: if (reg_ack) state <= S_NC_WR;
                S_NC_WR: if (reg_ack) state <= S_STRM;
                S_STRM: if (word_valid) begin
                    wbuf   <= masked;
                    last_q <= word_last;
                    state  <= S_DWR;
                end
                S_DWR: if (reg_ack) begin
                    if (chk_en && (chunk_end || last_q)) state <= S_ECHK;
                    else if (last_q) begin td_ret <= S_LAT; state <= S_TD_RD; end
                    else state <= S_STRM;
                end
                S_ECHK: if (reg_ack) begin
                    if (reg_rdata[B_CERR]) begin err_q <= E_CFGERR; state <= S_FIN; end
                    else if (last_q) begin td_ret <= S_LAT; state <= S_TD_RD; end
                    else state <= S_STRM;
                end
                S_TD_RD:  if (reg_ack) state <= S_TD_WR1;
                S_TD_WR1: if (reg_ack) state <= S_TD_WR2;
                S_TD_WR2: if (reg_ack) begin sw_ret <= S_POLL0; state <= S_SW_RD; end
                S_POLL0: if (reg_ack) begin
                    if (!reg_rdata[B_RDY]) state <= td_ret;
                    else if (to_hit) begin err_q <= E_RDY0_TO; state <= S_FIN; end
                end
                S_LAT: if (reg_ack) begin
                    if (reg_rdata[B_LATCH]) begin err_q <= E_LATCHED; state <= S_FIN; end
                    else state <= S_UM_RD;
                end
                S_UM_RD: if (reg_ack) state <= S_UM_WR;
                S_UM_WR: if (reg_ack) state <= S_POLLU;
                S_POLLU: if (reg_ack) begin
                    if (reg_rdata[B_UMODE] && reg_rdata[B_FCLK]) state <= S_FIN;
                    else if (to_hit) begin err_q <= E_USER_TO; state <= S_FIN; end
                end
                S_FIN: begin done_q <= 1'b1; state <= S_IDLE; end
                default: state <= S_IDLE;
            endcase
        end
    end

    // R1: a pending request holds its command until acknowledged.
    p_bus_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && !reg_ack) |=> (reg_req && $stable(reg_addr) && $stable(reg_we) && $stable(reg_wdata)));

    // R7: a stream word is never taken while a bus transaction is pending.
    p_stream_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        word_ready |-> !reg_req);

    // R12: the end-of-run pulse comes with busy already low.
    p_done_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R12: a run only begins after a start request.
    p_start_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R12: the result code holds while idle without a start.
    p_err_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(err_code));

    // R12: done is a single-cycle pulse.
    p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: tb/cfg_load_seq_tb.sv
// Directed bench for cfg_load_seq with a behavioural target model.
module cfg_load_seq_tb;
    localparam int TW = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  img_type = 2'b00;
    logic        chk_en = 1'b0;
    logic [TW-1:0] poll_limit = 16'd20;
    logic        word_valid, word_last, word_ready;
    logic [31:0] word_data;
    logic [1:0]  word_bytes;
    logic        reg_req, reg_we, reg_ack, busy, done;
    logic [7:0]  reg_addr;
    logic [31:0] reg_wdata, reg_rdata;
    logic [3:0]  err_code;

    always #4 clk = ~clk;

    cfg_load_seq #(.TW(TW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .img_type(img_type),
        .chk_en(chk_en), .poll_limit(poll_limit),
        .word_valid(word_valid), .word_data(word_data), .word_last(word_last),
        .word_bytes(word_bytes), .word_ready(word_ready),
        .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_ack(reg_ack), .reg_rdata(reg_rdata),
        .busy(busy), .done(done), .err_code(err_code));

    // Target model configuration (set by tasks)
    logic m_clr = 1'b0, m_run = 1'b0;
    logic c_en = 1'b1, c_rdy_init = 1'b0, c_rdy_never = 1'b0, c_rdy_stuck = 1'b0;
    logic c_latch = 1'b0, c_um_ok = 1'b1;
    int   c_err_from = 0, c_nwords = 1;
    logic [1:0] c_tail = 2'd0;

    // Target model state
    logic [31:0] mode_r, prog_r, mw0, mw1;
    logic        rdy;
    int widx, dcnt, dum_cnt, dum_bad, data_bad, mw_cnt, stat_rd, bus_bad, nclk_seen;
    logic        pend;
    logic [7:0]  pend_addr;

    function automatic logic [31:0] gen(int i);
        return 32'hC0DE_0000 ^ (i * 32'h0001_0103) ^ {i[7:0], 24'h0};
    endfunction

    function automatic logic [31:0] expw(int i);
        if (i == c_nwords - 1 && c_tail != 2'd0)
            return gen(i) & ((32'h1 << (8 * int'(c_tail))) - 32'h1);
        return gen(i);
    endfunction

    wire um_bit = c_um_ok && (mode_r[1:0] == 2'b00);
    wire cerr   = (c_err_from != 0) && (dcnt >= c_err_from);

    assign word_valid = m_run && (widx < c_nwords);
    assign word_data  = gen(widx);
    assign word_last  = (widx == c_nwords - 1);
    assign word_bytes = c_tail;

    // Behavioural target: registered acknowledge, register effects on ack.
    always @(posedge clk) begin
        if (m_clr) begin
            mode_r <= 32'h00AB_0000; prog_r <= 32'h0;
            rdy <= c_rdy_init; reg_ack <= 1'b0; reg_rdata <= '0;
            widx <= 0; dcnt <= 0; dum_cnt <= 0; dum_bad <= 0; data_bad <= 0;
            mw_cnt <= 0; mw0 <= '0; mw1 <= '0; stat_rd <= 0; bus_bad <= 0;
            nclk_seen <= -1; pend <= 1'b0; pend_addr <= '0;
        end else begin
            if (pend && (!reg_req || reg_addr != pend_addr)) bus_bad <= bus_bad + 1;
            pend      <= reg_req && !reg_ack;
            pend_addr <= reg_addr;
            if (reg_req && !reg_ack) begin
                reg_ack <= 1'b1;
                if (reg_we) begin
                    case (reg_addr)
                        8'h20: begin
                            mode_r <= reg_wdata;
                            if (mw_cnt == 0) mw0 <= reg_wdata;
                            if (mw_cnt == 1) mw1 <= reg_wdata;
                            mw_cnt <= mw_cnt + 1;
                        end
                        8'h2C: begin
                            prog_r <= reg_wdata;
                            if (reg_wdata[0] && !c_rdy_never) rdy <= 1'b1;
                            if (!reg_wdata[0] && !c_rdy_stuck) rdy <= 1'b0;
                        end
                        8'h28: begin
                            if (prog_r[1]) begin
                                if (dcnt == 0) nclk_seen <= int'(mode_r[15:8]);
                                if (reg_wdata != expw(dcnt)) data_bad <= data_bad + 1;
                                dcnt <= dcnt + 1;
                            end else begin
                                dum_cnt <= dum_cnt + 1;
                                if (mode_r[15:8] != 8'd1) dum_bad <= dum_bad + 1;
                            end
                        end
                        default: ;
                    endcase
                end else begin
                    case (reg_addr)
                        8'h1C: begin
                            reg_rdata <= '0;
                            reg_rdata[18] <= rdy;
                            reg_rdata[19] <= cerr;
                            reg_rdata[20] <= c_en;
                            reg_rdata[21] <= um_bit;
                            reg_rdata[24] <= um_bit;
                            stat_rd <= stat_rd + 1;
                        end
                        8'h20: reg_rdata <= mode_r;
                        8'h2C: reg_rdata <= prog_r;
                        8'h34: reg_rdata <= {26'h0, c_latch, 5'h0};
                        default: reg_rdata <= '0;
                    endcase
                end
            end else begin
                reg_ack <= 1'b0;
            end
            if (word_valid && word_ready) widx <= widx + 1;
        end
    end

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    task automatic chk_eq(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run_case(input logic en, input logic rinit, input logic rnever,
                            input logic rstuck, input logic latch, input logic umok,
                            input int efrom, input int nw, input logic [1:0] tail,
                            input logic [1:0] img, input logic chk);
        int t;
        @(negedge clk);
        c_en = en; c_rdy_init = rinit; c_rdy_never = rnever; c_rdy_stuck = rstuck;
        c_latch = latch; c_um_ok = umok; c_err_from = efrom; c_nwords = nw; c_tail = tail;
        m_clr = 1'b1;
        @(negedge clk);
        m_clr = 1'b0; m_run = 1'b1; img_type = img; chk_en = chk; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        t = 0;
        while (!done && t < 60000) begin @(negedge clk); t++; end
        chk_eq("R12 done seen", longint'(done), 1);
        chk_eq("R12 busy low at done", longint'(busy), 0);
        @(negedge clk);
        chk_eq("R12 done one cycle", longint'(done), 0);
        m_run = 1'b0;
    endtask

    task automatic t_reset;
        chk_eq("R12 reset busy", longint'(busy), 0);
        chk_eq("R12 reset done", longint'(done), 0);
        chk_eq("R12 reset err", longint'(err_code), 0);
        chk_eq("R1 reset req", longint'(reg_req), 0);
        chk_eq("R7 reset ready", longint'(word_ready), 0);
    endtask

    task automatic t_plain;
        run_case(1, 0, 0, 0, 0, 1, 0, 5, 2'd0, 2'b00, 0);
        chk_eq("R10 plain result", longint'(err_code), 0);
        chk_eq("R4 dummy count", dum_cnt, 732);
        chk_eq("R4 dummy numclks", dum_bad, 0);
        chk_eq("R4 upper mode bits kept", longint'(mode_r[31:16]), 16'h00AB);
        chk_eq("R3 first mode write bits", longint'(mw0[1:0]), 2);
        chk_eq("R3 second mode write bits", longint'(mw1[1:0]), 3);
        chk_eq("R6 plain numclks", nclk_seen, 1);
        chk_eq("R7 word count", dcnt, 5);
        chk_eq("R7 word data", data_bad, 0);
        chk_eq("R8 prog bits cleared", longint'(prog_r[1:0]), 0);
        chk_eq("R10 mode bits cleared", longint'(mode_r[1:0]), 0);
        chk_eq("R1 bus hold", bus_bad, 0);
    endtask

    task automatic t_encrypted;
        run_case(1, 0, 0, 0, 0, 1, 0, 4, 2'd3, 2'b01, 0);
        chk_eq("R6 encrypted numclks", nclk_seen, 4);
        chk_eq("R7 tail 3 bytes", data_bad, 0);
        chk_eq("R10 encrypted result", longint'(err_code), 0);
    endtask

    task automatic t_compressed;
        run_case(1, 0, 0, 0, 0, 1, 0, 3, 2'd1, 2'b10, 0);
        chk_eq("R6 compressed numclks", nclk_seen, 8);
        chk_eq("R7 tail 1 byte", data_bad, 0);
        run_case(1, 0, 0, 0, 0, 1, 0, 2, 2'd2, 2'b11, 0);
        chk_eq("R6 compressed+encrypted numclks", nclk_seen, 8);
        chk_eq("R7 tail 2 bytes", data_bad, 0);
    endtask

    task automatic t_noload;
        run_case(0, 0, 0, 0, 0, 1, 0, 3, 2'd0, 2'b00, 0);
        chk_eq("R2 refused code", longint'(err_code), 1);
        chk_eq("R2 no mode write", mw_cnt, 0);
        chk_eq("R2 no data write", dum_cnt + dcnt, 0);
        chk_eq("R2 prog untouched", longint'(prog_r), 0);
        @(negedge clk);
        chk_eq("R12 err held", longint'(err_code), 1);
    endtask

    task automatic t_preready;
        run_case(1, 1, 0, 0, 0, 1, 0, 3, 2'd0, 2'b00, 0);
        chk_eq("R9 result", longint'(err_code), 0);
        chk_eq("R9 dummy count", dum_cnt, 976);
        chk_eq("R9 word count", dcnt, 3);
    endtask

    task automatic t_rdy1_to;
        run_case(1, 0, 1, 0, 0, 1, 0, 3, 2'd0, 2'b00, 0);
        chk_eq("R5 timeout code", longint'(err_code), 2);
        chk_eq("R12 status reads", stat_rd, 21);
        chk_eq("R5 no stream", dcnt, 0);
    endtask

    task automatic t_rdy0_to;
        run_case(1, 0, 0, 1, 0, 1, 0, 3, 2'd0, 2'b00, 0);
        chk_eq("R8 timeout code", longint'(err_code), 3);
        chk_eq("R8 prog bits cleared", longint'(prog_r[1:0]), 0);
    endtask

    task automatic t_latched;
        run_case(1, 0, 0, 0, 1, 1, 0, 3, 2'd0, 2'b00, 0);
        chk_eq("R10 latched code", longint'(err_code), 4);
        chk_eq("R10 mode left set", longint'(mode_r[1:0]), 3);
    endtask

    task automatic t_user_to;
        run_case(1, 0, 0, 0, 0, 0, 0, 3, 2'd0, 2'b00, 0);
        chk_eq("R10 user timeout code", longint'(err_code), 5);
    endtask

    task automatic t_cfgerr;
        run_case(1, 0, 0, 0, 0, 1, 1, 1030, 2'd0, 2'b00, 1);
        chk_eq("R11 chunk check code", longint'(err_code), 6);
        chk_eq("R11 stop at chunk", dcnt, 1024);
        run_case(1, 0, 0, 0, 0, 1, 3, 3, 2'd0, 2'b00, 1);
        chk_eq("R11 end check code", longint'(err_code), 6);
        chk_eq("R11 end words", dcnt, 3);
        run_case(1, 0, 0, 0, 0, 1, 0, 5, 2'd0, 2'b00, 1);
        chk_eq("R11 clean with checks", longint'(err_code), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        m_clr = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_clr = 1'b0;
        @(negedge clk);
        t_reset;
        t_plain;
        t_encrypted;
        t_compressed;
        t_noload;
        t_preready;
        t_rdy1_to;
        t_rdy0_to;
        t_latched;
        t_user_to;
        t_cfgerr;
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule